// File: doc/BRIEF.md
# TDM Serial Voice Port

This block connects a four-wire time-division-multiplexed serial bus to two host-side voice channels. The bus side has a data input, an open-drain data output (shown as a pull-down enable), a frame-sync strobe and a data clock. The host side has a 16-bit outbound word, a 16-bit inbound word and a per-channel completion strobe. A frame starts on a rising frame-sync edge and is made of 8-bit slots. The number of slots follows from the selected bit rate, which is n × 256 kbit/s.

Each of the two channels has its own start slot. In byte mode a channel moves one 8-bit companded sample. Channel 0 uses the low byte of each buffer and channel 1 the high byte. In wide mode channel 0 moves a 16-bit linear sample across two adjacent slots, and channel 1 is idle. In slave operation the bus clock and frame sync are inputs. They are synchronised into the system clock, and their edges set the bit timing. In master operation the port generates both signals from the system clock. The bus clock either runs at twice the bit rate (two clock periods per bit) or, in speech mode, at the bit rate itself.

Top module: `tdm_voice_port`

## Requirements
- R1: Rate codes 000 (the reset value), 001 and 111 disable the port. While disabled, the port never pulls the data line low, raises no done strobe, leaves rx_buf unchanged and holds the master clock and sync outputs at 0.
- R2: Codes 010, 011, 100, 101 and 110 give 4, 8, 12, 16 and 32 slots per frame. A channel whose slots lie at or beyond that count never transfers.
- R3: A frame-sync level that is high at a data-clock rising edge, after being low at the previous rising edge, starts bit 0 of slot 0. Slot k holds frame bits 8k to 8k+7, sent and received MSB first.
- R4: In doubled-clock mode (cfg_speech=0) a bit lasts two data-clock periods. The output bit is launched at the first rising edge and the input bit is sampled at the second.
- R5: In speech mode (cfg_speech=1) a bit lasts one data-clock period. The output bit is launched at the rising edge and the input bit is sampled at the falling edge.
- R6: In byte mode (cfg_wide=0), channel 0 moves buffer bits [7:0] in slot cfg_start0, and channel 1 moves bits [15:8] in slot cfg_start1.
- R7: In wide mode (cfg_wide=1), channel 0 moves all 16 buffer bits. Bits [15:8] go in slot cfg_start0 and bits [7:0] in the following slot. Channel 1 does not transfer.
- R8: ser_dout_pd is 1 only during a bit of an owned slot whose outbound value is 0. At all other times it is 0 (line released).
- R9: After the last bit of a channel is sampled, that channel's bytes of rx_buf take the received data, and rx_done[channel] is high for exactly one clock. rx_buf changes at no other time.
- R10: tx_buf is captured at each frame start. A change in the middle of a frame first appears on the line in the next frame.
- R11: In master mode with the port enabled, ser_clk_drive is 1. ser_dclk_out toggles every MST_HALF clocks. ser_fsync_out rises with ser_dclk_out, stays high for the first bit and repeats every (slots × 8 × 2 × 2 × MST_HALF) clocks in doubled mode. Otherwise both outputs are 0.
- R12: If both byte channels name the same slot, channel 0 owns it and channel 1 does not transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 3 | Bit-rate code; also enables or disables the port |
| cfg_master | input | 1 | 1 = generate clock and sync, 0 = slave |
| cfg_speech | input | 1 | 1 = clock equals bit rate, 0 = doubled clock |
| cfg_wide | input | 1 | 1 = 16-bit sample on channel 0 over two slots |
| cfg_start0 | input | 5 | First slot of channel 0 |
| cfg_start1 | input | 5 | Slot of channel 1 |
| tx_buf | input | 16 | Outbound samples (high byte channel 1) |
| rx_buf | output | 16 | Inbound samples (high byte channel 1) |
| rx_done | output | 2 | One-clock completion strobe per channel |
| ser_din | input | 1 | Serial data in |
| ser_dout_pd | output | 1 | Pull-down enable for the shared data line |
| ser_fsync_in | input | 1 | Frame sync in (slave) |
| ser_dclk_in | input | 1 | Data clock in (slave) |
| ser_fsync_out | output | 1 | Frame sync out (master) |
| ser_dclk_out | output | 1 | Data clock out (master) |
| ser_clk_drive | output | 1 | Output enable for the clock and sync pins |

## Verification
The hardest cases to reach from the ports are the ones where a channel's slots meet the edge of the frame. These include a start slot on the last slot of the frame, a wide pair whose second slot falls outside the frame, a start slot past the frame, and two byte channels that name the same slot. They also include an outbound word that changes in the middle of a frame. Directed frames place the start slots on exactly those edges, and every frame rewrites tx_buf halfway through. Seeded random frames then mix rates, clock modes, widths and start slots, and a bench function predicts each line bit, each done strobe and the resulting inbound word.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int SLOT_W = 5;
    localparam int CNT_W  = 6;
    localparam int BIT_W  = 9;
    localparam int BUF_W  = 16;
    localparam int NCH    = 2;

    typedef enum logic [2:0] {
        RATE_OFF_A = 3'b000,
        RATE_OFF_B = 3'b001,
        RATE_X1    = 3'b010,
        RATE_X2    = 3'b011,
        RATE_X3    = 3'b100,
        RATE_X4    = 3'b101,
        RATE_X8    = 3'b110,
        RATE_OFF_C = 3'b111
    } rate_code_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic frame_start;
    } clk_evt_t;

    typedef struct packed {
        logic       hit;
        logic       chan;
        logic [3:0] pos;
        logic       last;
    } slot_hit_t;

    function automatic logic [CNT_W-1:0] slots_per_frame(input logic [2:0] code);
        case (rate_code_e'(code))
            RATE_X1: return 6'd4;
            RATE_X2: return 6'd8;
            RATE_X3: return 6'd12;
            RATE_X4: return 6'd16;
            RATE_X8: return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic [BIT_W-1:0] frame_len(input logic [CNT_W-1:0] slots);
        return {slots, 3'b000};
    endfunction

endpackage

// File: rtl/tdm_clk_front.sv
module tdm_clk_front
    import tdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MST_HALF    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             master,
    input  logic             speech,
    input  logic [CNT_W-1:0] slots,
    input  logic             dclk_in,
    input  logic             fsync_in,
    input  logic             din,
    output clk_evt_t         evt,
    output logic             din_s,
    output logic             dclk_out,
    output logic             fsync_out
);
    localparam int TOP    = SYNC_STAGES - 1;
    localparam int HALF_W = $clog2(MST_HALF) + 1;
    localparam int RISE_W = BIT_W + 1;

    // Slave path: synchronise the bus clock, sync and data together
    logic [SYNC_STAGES-1:0] dclk_sh, fs_sh, din_sh;
    logic                   dclk_prev, fs_last;
    clk_evt_t               s_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_sh   <= '0;
            fs_sh     <= '0;
            din_sh    <= '0;
            dclk_prev <= 1'b0;
            fs_last   <= 1'b0;
        end else begin
            dclk_sh   <= {dclk_sh[SYNC_STAGES-2:0], dclk_in};
            fs_sh     <= {fs_sh[SYNC_STAGES-2:0], fsync_in};
            din_sh    <= {din_sh[SYNC_STAGES-2:0], din};
            dclk_prev <= dclk_sh[TOP];
            if (s_evt.rise) fs_last <= fs_sh[TOP];
        end
    end

    always_comb begin
        s_evt.rise        = dclk_sh[TOP] & ~dclk_prev;
        s_evt.fall        = ~dclk_sh[TOP] & dclk_prev;
        s_evt.frame_start = s_evt.rise & fs_sh[TOP] & ~fs_last;
    end

    assign din_s = din_sh[TOP];

    // Master path: clock and sync generated from the system clock
    logic [HALF_W-1:0] half_cnt;
    logic [RISE_W-1:0] rise_cnt, rises_per_frame, rises_per_bit;
    logic              mclk, mfs, m_active, m_tick;
    clk_evt_t          m_evt;

    assign m_active        = en & master;
    assign m_tick          = m_active && (half_cnt == HALF_W'(MST_HALF - 1));
    assign rises_per_frame = speech ? {1'b0, frame_len(slots)} : {frame_len(slots), 1'b0};
    assign rises_per_bit   = speech ? RISE_W'(1) : RISE_W'(2);

    always_ff @(posedge clk) begin
        if (rst || !m_active) begin
            half_cnt <= '0;
            mclk     <= 1'b0;
            mfs      <= 1'b0;
            rise_cnt <= '0;
        end else if (m_tick) begin
            half_cnt <= '0;
            mclk     <= ~mclk;
            if (!mclk) begin
                mfs      <= (rise_cnt < rises_per_bit);
                rise_cnt <= (rise_cnt >= rises_per_frame - 1'b1) ? '0 : rise_cnt + 1'b1;
            end
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    always_comb begin
        m_evt.rise        = m_tick & ~mclk;
        m_evt.fall        = m_tick & mclk;
        m_evt.frame_start = m_tick & ~mclk & (rise_cnt == '0);
    end

    assign evt       = !en ? clk_evt_t'('0) : (master ? m_evt : s_evt);
    assign dclk_out  = mclk;
    assign fsync_out = mfs;

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_pkg::*;
(
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [CNT_W-1:0]  slots,
    input  logic              wide,
    input  logic [SLOT_W-1:0] start0,
    input  logic [SLOT_W-1:0] start1,
    output slot_hit_t         hit
);
    logic [CNT_W-1:0] slot, s0, s0_next, s1;
    logic [2:0]       sub;
    logic             in_frame;

    assign slot     = bit_idx[BIT_W-1:3];
    assign sub      = bit_idx[2:0];
    assign s0       = {1'b0, start0};
    assign s0_next  = s0 + 1'b1;
    assign s1       = {1'b0, start1};
    assign in_frame = bit_idx < frame_len(slots);

    always_comb begin
        hit = '0;
        if (in_frame) begin
            if (wide) begin
                if (slot == s0) begin
                    hit.hit = 1'b1;
                    hit.pos = {1'b1, ~sub};
                end else if (slot == s0_next) begin
                    hit.hit  = 1'b1;
                    hit.pos  = {1'b0, ~sub};
                    hit.last = (sub == 3'd7);
                end
            end else if (slot == s0) begin
                hit.hit  = 1'b1;
                hit.pos  = {1'b0, ~sub};
                hit.last = (sub == 3'd7);
            end else if (slot == s1) begin
                hit.hit  = 1'b1;
                hit.chan = 1'b1;
                hit.pos  = {1'b1, ~sub};
                hit.last = (sub == 3'd7);
            end
        end
    end

endmodule

// File: rtl/tdm_bit_engine.sv
module tdm_bit_engine
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              speech,
    input  logic              wide,
    input  logic [CNT_W-1:0]  slots,
    input  logic [SLOT_W-1:0] start0,
    input  logic [SLOT_W-1:0] start1,
    input  clk_evt_t          evt,
    input  logic              din_s,
    input  logic [BUF_W-1:0]  tx_buf,
    output logic              dout_pd,
    output logic [BUF_W-1:0]  rx_buf,
    output logic [NCH-1:0]    rx_done
);
    localparam logic [BIT_W-1:0] IDLE = '1;

    logic [BIT_W-1:0] bit_idx;
    logic             phase;
    logic [BUF_W-1:0] tx_snap, rx_sh, rx_nxt;
    logic             launch, sample;
    slot_hit_t        hit;

    tdm_slot_map u_map (
        .bit_idx (bit_idx),
        .slots   (slots),
        .wide    (wide),
        .start0  (start0),
        .start1  (start1),
        .hit     (hit)
    );

    assign launch  = evt.rise & ~evt.frame_start & (speech | phase);
    assign sample  = speech ? evt.fall : (evt.rise & ~phase & ~evt.frame_start);
    assign rx_nxt  = {rx_sh[BUF_W-2:0], din_s};
    assign dout_pd = en & hit.hit & ~tx_snap[hit.pos];

    always_ff @(posedge clk) begin
        rx_done <= '0;
        if (rst) begin
            bit_idx <= IDLE;
            phase   <= 1'b0;
            tx_snap <= '0;
            rx_sh   <= '0;
            rx_buf  <= '0;
        end else if (!en) begin
            bit_idx <= IDLE;
            phase   <= 1'b0;
        end else begin
            if (evt.frame_start) begin
                bit_idx <= '0;
                phase   <= 1'b0;
                tx_snap <= tx_buf;
            end else if (launch) begin
                phase <= 1'b0;
                if (bit_idx < frame_len(slots)) bit_idx <= bit_idx + 1'b1;
            end else if (evt.rise) begin
                phase <= 1'b1;
            end
            if (sample && hit.hit) begin
                rx_sh <= rx_nxt;
                if (hit.last) begin
                    rx_done[hit.chan] <= 1'b1;
                    if (wide)          rx_buf        <= rx_nxt;
                    else if (hit.chan) rx_buf[15:8]  <= rx_nxt[7:0];
                    else               rx_buf[7:0]   <= rx_nxt[7:0];
                end
            end
        end
    end

endmodule

// File: rtl/tdm_voice_port.sv
module tdm_voice_port
    import tdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MST_HALF    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_rate,
    input  logic              cfg_master,
    input  logic              cfg_speech,
    input  logic              cfg_wide,
    input  logic [SLOT_W-1:0] cfg_start0,
    input  logic [SLOT_W-1:0] cfg_start1,
    input  logic [BUF_W-1:0]  tx_buf,
    output logic [BUF_W-1:0]  rx_buf,
    output logic [NCH-1:0]    rx_done,
    input  logic              ser_din,
    output logic              ser_dout_pd,
    input  logic              ser_fsync_in,
    input  logic              ser_dclk_in,
    output logic              ser_fsync_out,
    output logic              ser_dclk_out,
    output logic              ser_clk_drive
);
    logic [CNT_W-1:0] slots;
    logic             en, din_s;
    clk_evt_t         evt;

    assign slots         = slots_per_frame(cfg_rate);
    assign en            = (slots != '0);
    assign ser_clk_drive = en & cfg_master;

    tdm_clk_front #(
        .SYNC_STAGES (SYNC_STAGES),
        .MST_HALF    (MST_HALF)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .master    (cfg_master),
        .speech    (cfg_speech),
        .slots     (slots),
        .dclk_in   (ser_dclk_in),
        .fsync_in  (ser_fsync_in),
        .din       (ser_din),
        .evt       (evt),
        .din_s     (din_s),
        .dclk_out  (ser_dclk_out),
        .fsync_out (ser_fsync_out)
    );

    tdm_bit_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .speech  (cfg_speech),
        .wide    (cfg_wide),
        .slots   (slots),
        .start0  (cfg_start0),
        .start1  (cfg_start1),
        .evt     (evt),
        .din_s   (din_s),
        .tx_buf  (tx_buf),
        .dout_pd (ser_dout_pd),
        .rx_buf  (rx_buf),
        .rx_done (rx_done)
    );

endmodule

// File: rtl/tdm_voice_port_chk.sv
module tdm_voice_port_chk
    import tdm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cfg_rate,
    input logic              cfg_wide,
    input logic [BUF_W-1:0]  rx_buf,
    input logic [NCH-1:0]    rx_done,
    input logic              ser_dout_pd,
    input logic              ser_fsync_out,
    input logic              ser_dclk_out,
    input logic              ser_clk_drive
);
    logic off;
    assign off = (slots_per_frame(cfg_rate) == '0);

    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        (off && $past(off)) |-> (!ser_dout_pd && rx_done == 2'b00 && !ser_clk_drive));

    p_done0_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rx_done[0] |=> !rx_done[0]);

    p_done1_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rx_done[1] |=> !rx_done[1]);

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_buf) |-> (rx_done != 2'b00));

    p_wide_ch1_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wide && $past(cfg_wide)) |-> !rx_done[1]);

    p_master_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!ser_clk_drive && $past(!ser_clk_drive)) |-> (!ser_dclk_out && !ser_fsync_out));

    p_sync_on_clk_rise_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_fsync_out) |-> $rose(ser_dclk_out));

endmodule

bind tdm_voice_port tdm_voice_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_rate      (cfg_rate),
    .cfg_wide      (cfg_wide),
    .rx_buf        (rx_buf),
    .rx_done       (rx_done),
    .ser_dout_pd   (ser_dout_pd),
    .ser_fsync_out (ser_fsync_out),
    .ser_dclk_out  (ser_dclk_out),
    .ser_clk_drive (ser_clk_drive)
);

// File: tb/tdm_voice_port_test.sv
module tdm_voice_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int MST_HALF   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_rate = 3'b000;
    logic        cfg_master = 1'b0, cfg_speech = 1'b0, cfg_wide = 1'b0;
    logic [4:0]  cfg_start0 = '0, cfg_start1 = '0;
    logic [15:0] tx_buf = '0;
    logic [15:0] rx_buf;
    logic [1:0]  rx_done;
    logic        ser_din = 1'b0, ser_fsync_in = 1'b0, ser_dclk_in = 1'b0;
    logic        ser_dout_pd, ser_fsync_out, ser_dclk_out, ser_clk_drive;

    int errors = 0;
    int checks = 0;
    int done0 = 0;
    int done1 = 0;
    logic [15:0] exp_rx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_voice_port #(.SYNC_STAGES(2), .MST_HALF(MST_HALF)) uut (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_master(cfg_master),
        .cfg_speech(cfg_speech), .cfg_wide(cfg_wide), .cfg_start0(cfg_start0),
        .cfg_start1(cfg_start1), .tx_buf(tx_buf), .rx_buf(rx_buf), .rx_done(rx_done),
        .ser_din(ser_din), .ser_dout_pd(ser_dout_pd), .ser_fsync_in(ser_fsync_in),
        .ser_dclk_in(ser_dclk_in), .ser_fsync_out(ser_fsync_out),
        .ser_dclk_out(ser_dclk_out), .ser_clk_drive(ser_clk_drive)
    );

    always @(negedge clk) begin
        if (rx_done[0]) done0 <= done0 + 1;
        if (rx_done[1]) done1 <= done1 + 1;
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bslots(input logic [2:0] code);
        case (code)
            3'b010: return 4;
            3'b011: return 8;
            3'b100: return 12;
            3'b101: return 16;
            3'b110: return 32;
            default: return 0;
        endcase
    endfunction

    // Buffer bit carried by frame bit b, or -1 if the port does not own it
    function automatic int owner_pos(input int b, input int slots, input logic wide,
                                     input int s0, input int s1);
        int sl = b / 8;
        int sub = b % 8;
        if (b >= slots * 8) return -1;
        if (wide) begin
            if (sl == s0) return 15 - sub;
            if (sl == s0 + 1) return 7 - sub;
            return -1;
        end
        if (sl == s0) return 7 - sub;
        if (sl == s1) return 15 - sub;
        return -1;
    endfunction

    task automatic dclk_period();
        ser_dclk_in = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_dclk_in = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] rxw, input logic [15:0] txw, input string req);
        int slots = bslots(cfg_rate);
        int bits = slots * 8;
        int per = cfg_speech ? 1 : 2;
        int s0 = int'(cfg_start0);
        int s1 = int'(cfg_start1);
        bit e0, e1;
        @(negedge clk);
        tx_buf = txw;
        done0 = 0;
        done1 = 0;
        for (int b = 0; b < bits; b++) begin
            int p;
            p = owner_pos(b, slots, cfg_wide, s0, s1);
            ser_fsync_in = (b == 0);
            ser_din = (p >= 0) ? rxw[p] : 1'($urandom);
            if (b == bits / 2) tx_buf = ~txw;   // R10: mid-frame change must not show
            for (int k = 0; k < per; k++) dclk_period();
            check_eq(req, 32'(ser_dout_pd), (p >= 0) ? 32'(!txw[p]) : 32'd0);
        end
        ser_fsync_in = 1'b0;
        repeat (4) @(negedge clk);
        e0 = cfg_wide ? (s0 + 1 < slots) : (s0 < slots);
        e1 = !cfg_wide && (s1 < slots) && (s1 != s0);
        if (e0) begin
            if (cfg_wide) exp_rx = rxw;
            else exp_rx[7:0] = rxw[7:0];
        end
        if (e1) exp_rx[15:8] = rxw[15:8];
        check_eq({req, " R9 rx_buf"}, 32'(rx_buf), 32'(exp_rx));
        check_eq({req, " R9 done0"}, 32'(done0), 32'(e0));
        check_eq({req, " R9 done1"}, 32'(done1), 32'(e1));
    endtask

    task automatic run_quiet(input logic [2:0] code);
        cfg_rate = code;
        cfg_master = 1'b1;
        @(negedge clk);
        done0 = 0;
        done1 = 0;
        tx_buf = 16'h0000;
        for (int b = 0; b < 16; b++) begin
            ser_fsync_in = (b == 0);
            ser_din = 1'($urandom);
            dclk_period();
            check_eq("R1 dout", 32'(ser_dout_pd), 32'd0);
            check_eq("R1 master pins", 32'({ser_clk_drive, ser_dclk_out, ser_fsync_out}), 32'd0);
        end
        ser_fsync_in = 1'b0;
        cfg_master = 1'b0;
        check_eq("R1 done", 32'(done0 + done1), 32'd0);
        check_eq("R1 rx_buf", 32'(rx_buf), 32'(exp_rx));
    endtask

    task automatic wait_fs_rise(output int t);
        logic prev = ser_fsync_out;
        t = 0;
        forever begin
            @(negedge clk);
            t++;
            if (!prev && ser_fsync_out) break;
            prev = ser_fsync_out;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int gap, hi;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Reset state (R1)
        check_eq("R1 reset rx_buf", 32'(rx_buf), 32'd0);
        check_eq("R1 reset rx_done", 32'(rx_done), 32'd0);
        check_eq("R1 reset dout", 32'(ser_dout_pd), 32'd0);
        check_eq("R1 reset master pins", 32'({ser_clk_drive, ser_dclk_out, ser_fsync_out}), 32'd0);

        // Disabled codes (R1)
        run_quiet(3'b000);
        run_quiet(3'b001);
        run_quiet(3'b111);

        // Byte mode, 4 slots, doubled clock, channel 1 on the last slot
        cfg_rate = 3'b010; cfg_speech = 1'b0; cfg_wide = 1'b0;
        cfg_start0 = 5'd0; cfg_start1 = 5'd3;
        run_frame(16'hA55A, 16'h3CC3, "R2 R3 R4 R6 R8 R10");
        run_frame(16'h0FF0, 16'hF00F, "R2 R3 R4 R6 R8 R10");

        // Speech mode, 32 slots, channel 0 on the last slot
        cfg_rate = 3'b110; cfg_speech = 1'b1;
        cfg_start0 = 5'd31; cfg_start1 = 5'd5;
        run_frame(16'h1296, 16'h8E71, "R3 R5 R6 R8");

        // Wide mode, 8 slots, doubled clock; channel 1 configured but idle
        cfg_rate = 3'b011; cfg_speech = 1'b0; cfg_wide = 1'b1;
        cfg_start0 = 5'd2; cfg_start1 = 5'd6;
        run_frame(16'hC3A1, 16'h5E27, "R7 R8 R4");
        // Wide pair whose second slot falls past the frame
        cfg_start0 = 5'd7;
        run_frame(16'h7777, 16'h1234, "R7 R2");

        // Coincident byte slots: channel 0 wins
        cfg_wide = 1'b0; cfg_start0 = 5'd1; cfg_start1 = 5'd1;
        run_frame(16'h66E4, 16'h90A5, "R12 R6");

        // Start slot beyond the frame for channel 1
        cfg_rate = 3'b010; cfg_start0 = 5'd2; cfg_start1 = 5'd4;
        run_frame(16'hBEEF, 16'h0000, "R2 R6");

        // Seeded random frames
        for (int i = 0; i < 14; i++) begin
            int sl;
            cfg_rate = 3'(2 + ($urandom % 5));
            sl = bslots(cfg_rate);
            cfg_speech = 1'($urandom % 2);
            cfg_wide = (($urandom % 4) == 0);
            cfg_start0 = 5'($urandom % (sl + 1));
            cfg_start1 = 5'($urandom % (sl + 1));
            run_frame(16'($urandom), 16'($urandom), "R3 R4 R5 R6 R7 R8 R10 random");
        end

        // Master mode at the 12-slot rate, doubled clock (R11)
        cfg_rate = 3'b100; cfg_speech = 1'b0; cfg_master = 1'b1;
        @(negedge clk);
        check_eq("R11 drive", 32'(ser_clk_drive), 32'd1);
        wait_fs_rise(gap);
        wait_fs_rise(gap);
        check_eq("R11 frame period", 32'(gap), 32'(12 * 8 * 2 * 2 * MST_HALF));
        hi = 1;
        while (ser_fsync_out) begin
            @(negedge clk);
            if (ser_fsync_out) hi++;
        end
        check_eq("R11 sync width", 32'(hi), 32'(2 * 2 * MST_HALF));
        while (!ser_dclk_out) @(negedge clk);
        hi = 0;
        while (ser_dclk_out) begin
            hi++;
            @(negedge clk);
        end
        check_eq("R11 clock half period", 32'(hi), 32'(MST_HALF));
        cfg_master = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R11 slave pins low", 32'({ser_clk_drive, ser_dclk_out, ser_fsync_out}), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule